// File: doc/BRIEF.md
# Ethernet Frame Receiver with FCS Check

This block sits behind a PHY-side byte interface. While the data-valid input is high it takes one byte per clock. It hunts for the start-of-frame delimiter and ignores everything before it. Every byte after the delimiter, including the four FCS bytes, goes through a CRC-32 engine. Those same bytes are offered to a receive FIFO.

When data-valid drops after a frame body, the block compares the CRC register against the fixed residue that a correct frame leaves behind. It then gives a one-cycle good or bad status pulse. The FCS field is never compared as a field. The user side drains the FIFO through a read strobe and watches two flags: one for "holds data" and one for "full". A store-enable input decides whether received bytes are kept at all.

Top module: `eth_rx_fcs`

## Requirements
- R1: After reset, `frame_ok`, `frame_err`, `fifo_has_data` and `fifo_full` are all low.
- R2: A frame starts only on byte 0xD5 received directly after a byte 0x55. Bytes up to and including that 0xD5 are never stored. A 0xD5 that does not follow 0x55 does not start a frame.
- R3: Each byte received with `rx_dv` high after the delimiter is written to the FIFO when `store_en` is high, in arrival order. Frames carry up to 1500 payload bytes plus 4 FCS bytes.
- R4: A body byte received while `store_en` is low is not stored, but it still enters the CRC.
- R5: The CRC is preset to all ones at the delimiter. It uses polynomial 0x04C11DB7, processed LSB first in reflected form, 8 bits per body byte. If the register equals 0xDEBB20E3 when `rx_dv` is sampled low, `frame_ok` is high during the next cycle.
- R6: If the register holds any other value at that point, `frame_err` is high during the next cycle.
- R7: If `rx_dv` falls before a delimiter is accepted, neither status is raised and nothing is stored.
- R8: `frame_ok` and `frame_err` are never high together, and each is high for exactly one cycle per frame.
- R9: `fifo_has_data` is high while the FIFO holds at least one byte. `fifo_full` is high while it holds DEPTH bytes (16 by default). Bytes that arrive while the FIFO is full are dropped.
- R10: `rd_data` shows the oldest stored byte while `fifo_has_data` is high. `rd_en` removes that byte, and `rd_en` on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive byte qualifier from the PHY side |
| rx_data | input | 8 | Received byte |
| store_en | input | 1 | Write-enable handshake for the receive FIFO |
| rd_en | input | 1 | Pop the oldest FIFO byte |
| rd_data | output | 8 | Oldest FIFO byte (show-ahead) |
| fifo_has_data | output | 1 | FIFO holds at least one byte |
| fifo_full | output | 1 | FIFO holds DEPTH bytes |
| frame_ok | output | 1 | One-cycle pulse: residue matched |
| frame_err | output | 1 | One-cycle pulse: residue mismatched |

## Verification
The bench sends a stray byte before the preamble, and a delimiter with no preceding 0x55. A receiver that started frames too eagerly would store garbage and emit a status for a non-frame. A bit-flipped frame must give a bad pulse, while a good frame received with store disabled must still give a good pulse. A design that compared the FCS as a field, or skipped CRC updates on unstored bytes, would get one of these wrong. An oversized frame fills the FIFO and must keep exactly the first DEPTH bytes in order. Read strobes on an empty FIFO and back-to-back frames must leave neither phantom bytes nor stretched status pulses.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  localparam logic [31:0] CRC_POLY    = 32'h04C11DB7;
  localparam logic [31:0] CRC_PRESET  = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
  localparam logic [7:0]  PRE_BYTE    = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;

  typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_BODY} rx_state_e;

  function automatic logic [31:0] reflect32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // One byte through the reflected (LSB-first) CRC-32 register.
  function automatic logic [31:0] crc_step(input logic [31:0] crc, input logic [7:0] d);
    logic [31:0] c;
    c = crc ^ {24'd0, d};
    for (int i = 0; i < 8; i++)
      c = c[0] ? ((c >> 1) ^ reflect32(CRC_POLY)) : (c >> 1);
    return c;
  endfunction
endpackage

// File: rtl/rx_crc32.sv
module rx_crc32
  import eth_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       en,
  input  logic [7:0] data,
  output logic       match
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_PRESET;
    else if (clear) crc_q <= CRC_PRESET;
    else if (en)    crc_q <= crc_step(crc_q, data);
  end

  assign match = (crc_q == CRC_RESIDUE);

  assert_crc_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == CRC_PRESET));
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import eth_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_dv,
  input  logic [7:0] rx_data,
  input  logic       crc_match,
  output logic       body_byte,
  output logic       sfd_hit,
  output logic       frame_ok,
  output logic       frame_err
);
  rx_state_e state_q;
  logic      seen_pre_q;
  logic      in_body;
  logic      frame_end;

  assign in_body   = (state_q == RX_BODY);
  assign body_byte = rx_dv && in_body;
  assign sfd_hit   = rx_dv && !in_body && seen_pre_q && (rx_data == SFD_BYTE);
  assign frame_end = !rx_dv && in_body;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      seen_pre_q <= 1'b0;
      frame_ok   <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      frame_ok  <= frame_end && crc_match;
      frame_err <= frame_end && !crc_match;
      if (!rx_dv) begin
        state_q    <= RX_IDLE;
        seen_pre_q <= 1'b0;
      end else if (!in_body) begin
        state_q    <= sfd_hit ? RX_BODY : RX_HUNT;
        seen_pre_q <= (rx_data == PRE_BYTE);
      end
    end
  end

  assert_status_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_ok, frame_err}));
  assert_status_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok || frame_err) |=> !(frame_ok || frame_err));
  assert_status_needs_body_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_ok || frame_err) |-> $past(in_body && !rx_dv));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             has_data,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign has_data = (cnt_q != '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && has_data;
  assign rdata    = mem[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!has_data && !push) |=> !has_data);
endmodule

// File: rtl/eth_rx_fcs.sv
module eth_rx_fcs #(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_dv,
  input  logic [7:0] rx_data,
  input  logic       store_en,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       fifo_has_data,
  output logic       fifo_full,
  output logic       frame_ok,
  output logic       frame_err
);
  logic body_byte;
  logic sfd_hit;
  logic crc_match;
  logic fifo_push;

  rx_framer u_framer (
    .clk, .rst_n, .rx_dv, .rx_data,
    .crc_match (crc_match),
    .body_byte (body_byte),
    .sfd_hit   (sfd_hit),
    .frame_ok  (frame_ok),
    .frame_err (frame_err)
  );

  rx_crc32 u_crc (
    .clk, .rst_n,
    .clear (sfd_hit),
    .en    (body_byte),
    .data  (rx_data),
    .match (crc_match)
  );

  assign fifo_push = body_byte && store_en;

  rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk, .rst_n,
    .push     (fifo_push),
    .wdata    (rx_data),
    .pop      (rd_en),
    .rdata    (rd_data),
    .has_data (fifo_has_data),
    .full     (fifo_full)
  );

  assert_store_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_has_data && !(body_byte && store_en)) |=> !fifo_has_data);
endmodule

// File: tb/eth_rx_fcs_bench.sv
module eth_rx_fcs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_dv = 1'b0, store_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [7:0] rd_data;
  logic fifo_has_data, fifo_full, frame_ok, frame_err;

  int checks = 0, errors = 0, occ = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_fcs #(.FIFO_DEPTH(DEPTH)) u_eth_rx_fcs (
    .clk, .rst_n, .rx_dv, .rx_data, .store_en, .rd_en,
    .rd_data, .fifo_has_data, .fifo_full, .frame_ok, .frame_err
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench CRC: MSB-first register, input bits fed LSB first, result bit-reversed.
  function automatic logic [31:0] fcs_of(input logic [7:0] d[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] r;
    foreach (d[k])
      for (int b = 0; b < 8; b++) begin
        logic fb = c[31] ^ d[k][b];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    for (int i = 0; i < 32; i++) r[i] = c[31-i];
    return ~r;
  endfunction

  task automatic put(input logic [7:0] b, input bit st);
    @(negedge clk);
    rx_dv = 1'b1; rx_data = b; store_en = st;
  endtask

  // Driver: streams junk + preamble + SFD + body + FCS, fills the scoreboard.
  task automatic send_frame(input logic [7:0] body[$], input bit bad, input bit st,
                            input string req);
    logic [31:0] f = fcs_of(body);
    logic [7:0] w[$] = body;
    w.push_back(f[7:0]); w.push_back(f[15:8]);
    w.push_back(f[23:16]); w.push_back(f[31:24]);
    if (bad) w[0] = w[0] ^ 8'h01;
    put(8'h3C, st);
    for (int i = 0; i < 7; i++) put(8'h55, st);
    put(8'hD5, st);
    foreach (w[i]) begin
      put(w[i], st);
      if (st && occ < DEPTH) begin exp_q.push_back(w[i]); occ++; end
    end
    @(negedge clk); rx_dv = 1'b0; store_en = 1'b0;
    chk({req, " no early status R8"}, {frame_ok, frame_err}, 2'b00);
    @(negedge clk);
    chk({req, " status R5/R6"}, {frame_ok, frame_err}, bad ? 2'b01 : 2'b10);
    @(negedge clk);
    chk({req, " one-cycle pulse R8"}, {frame_ok, frame_err}, 2'b00);
  endtask

  // Monitor: pops the scoreboard against the read port.
  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      logic [7:0] e = exp_q.pop_front();
      chk({req, " has_data R9"}, fifo_has_data, 1'b1);
      chk({req, " data order R3/R10"}, rd_data, e);
      rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; occ--;
    end
    chk({req, " drained R9"}, fifo_has_data, 1'b0);
  endtask

  function automatic void mk(ref logic [7:0] q[$], input int n, input int seed);
    q.delete();
    for (int i = 0; i < n; i++) q.push_back(8'((i * 37 + seed) ^ (i >> 1)));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] body[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset R1", {frame_ok, frame_err, fifo_has_data, fifo_full}, 4'b0000);

    mk(body, 10, 5);
    send_frame(body, 1'b0, 1'b1, "good frame R2 R5");
    drain("good frame R3");

    send_frame(body, 1'b1, 1'b1, "bad frame R6");
    drain("bad frame R3");

    mk(body, 12, 91);
    send_frame(body, 1'b0, 1'b0, "no store R4");
    chk("no store R4 fifo empty", fifo_has_data, 1'b0);

    put(8'h12, 1'b1); put(8'hD5, 1'b1); put(8'h33, 1'b1);
    @(negedge clk); rx_dv = 1'b0; store_en = 1'b0;
    @(negedge clk);
    chk("lone SFD R2 R7 status", {frame_ok, frame_err}, 2'b00);
    chk("lone SFD R2 nothing stored", fifo_has_data, 1'b0);

    put(8'h55, 1'b1); put(8'h55, 1'b1);
    @(negedge clk); rx_dv = 1'b0; store_en = 1'b0;
    @(negedge clk);
    chk("abort in preamble R7", {frame_ok, frame_err}, 2'b00);

    mk(body, 20, 200);
    send_frame(body, 1'b0, 1'b1, "overflow R9");
    chk("overflow full R9", fifo_full, 1'b1);
    drain("overflow R9");
    chk("after drain not full R9", fifo_full, 1'b0);

    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;
    chk("pop on empty R10", fifo_has_data, 1'b0);
    mk(body, 6, 17);
    send_frame(body, 1'b0, 1'b1, "after empty pop R10");
    mk(body, 8, 77);
    send_frame(body, 1'b0, 1'b1, "back-to-back R8");
    drain("back-to-back R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule